// File: doc/BRIEF.md
# Event-to-Task Routing Matrix

This block is a crossbar that carries single-cycle event pulses from producing peripherals to single-cycle task pulses at consuming peripherals, without any processor in the path. It has a set of independent routing channels, 50 by default. Each channel holds three things: which incoming event line it watches, which outgoing task line it drives, and whether it is switched on. A single global run bit gates the whole matrix. While that bit is clear, no task pulse leaves the block.

Software configures the matrix through a small synchronous word-addressed register port. Channel switches are never written directly. A write of ones to a set word turns channels on, and a write of ones to a clear word turns them off. Status words read back the current switch state. Channel c lives in enable word c/32 at bit c%32, so the default 50 channels take all of word 0 and bits 0 to 17 of word 1. Any event can feed any task. Several channels may share an event (fan-out) or a task (the results are ORed together).

Top module: `evtask_matrix`

## Requirements
- R1: After synchronous active-high reset, every channel is disabled and the run bit is 0. Every channel's event index and task index read as all ones (63 with 6-bit indices, which is out of range), `task_out` is 0, and every status word reads 0.
- R2: A write to a set word (address 0x08 + w) enables each channel whose bit in wdata is 1 and leaves the other channels unchanged. Channel c maps to word c/32, bit c%32. Bits with no channel behind them (word 1 bits 18–31) read back as 0.
- R3: A write to a clear word (address 0x0C + w) disables each channel whose bit in wdata is 1 and leaves the other channels unchanged.
- R4: Registered readback with one cycle of latency. Address 0x00 bit 0 is the run bit. Address 0x04 + w is status word w. Address 0x40 + 2c holds channel c's event index, and 0x41 + 2c holds its task index.
- R5: While the run bit (written at address 0x00, bit 0) is 0, `task_out` stays 0 whatever the events and channel states.
- R6: With run set, an enabled channel whose selected event is high in cycle N raises its selected task bit in cycle N+1, for exactly the cycles the event was high.
- R7: A disabled channel never causes a task pulse.
- R8: When several enabled channels hit the same task in one cycle, that task bit is a single 1 (the results are ORed).
- R9: An event index of NUM_EVT or above never matches, and a task index of NUM_TASK or above never fires.
- R10: A configuration write to an enabled channel applies to events from the very next cycle onward.
- R11: One event routed by several channels to different tasks raises all of those tasks in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Word address for write and read |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data for the address of the previous cycle |
| evt_in | input | NUM_EVT (32) | Incoming event pulses |
| task_out | output | NUM_TASK (32) | Registered outgoing task pulses |

## Verification
The assertions assume that the register port performs at most one write per cycle. They also assume that `cfg_addr` and `cfg_wdata` hold known values whenever `cfg_wr` is high, and that `evt_in` is never unknown after reset. The bench meets these assumptions by driving every input on the falling clock edge from a single process, holding the address and data steady around each write strobe, and zeroing `evt_in` between pulses. Sampling also happens on the falling edge, so the one-cycle latency of both `task_out` and `cfg_rdata` is checked at a fixed cycle.

// File: rtl/evtask_pkg.sv
package evtask_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] A_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] A_STAT = 8'h04;
  localparam logic [ADDR_W-1:0] A_SET  = 8'h08;
  localparam logic [ADDR_W-1:0] A_CLR  = 8'h0C;
  localparam logic [ADDR_W-1:0] A_CFG  = 8'h40;
endpackage

// File: rtl/evtask_regs.sv
module evtask_regs
  import evtask_pkg::*;
#(
  parameter int NUM_CH = 50,
  parameter int IDX_W  = 6
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DATA_W-1:0]               wdata,
  output logic [DATA_W-1:0]               rdata,
  output logic                            run,
  output logic [NUM_CH-1:0]               ch_en,
  output logic [NUM_CH-1:0][IDX_W-1:0]    ch_evt,
  output logic [NUM_CH-1:0][IDX_W-1:0]    ch_task
);
  localparam int NWORDS = (NUM_CH + 31) / 32;
  localparam int W0     = (NUM_CH < 32) ? NUM_CH : 32;

  logic                         run_q;
  logic [NUM_CH-1:0]            en_q;
  logic [NUM_CH-1:0][IDX_W-1:0] evt_q;
  logic [NUM_CH-1:0][IDX_W-1:0] task_q;
  logic [NWORDS-1:0]            set_hit;
  logic [NWORDS-1:0]            clr_hit;
  logic [DATA_W-1:0]            rd_d;

  // word decode for the set and clear views
  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    assign set_hit[w] = wr_en && (addr == A_SET + ADDR_W'(w));
    assign clr_hit[w] = wr_en && (addr == A_CLR + ADDR_W'(w));
  end

  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else if (wr_en && addr == A_CTRL) run_q <= wdata[0];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int WI = c / 32;
    localparam int BI = c % 32;
    localparam logic [ADDR_W-1:0] AE = A_CFG + ADDR_W'(2 * c);
    localparam logic [ADDR_W-1:0] AT = A_CFG + ADDR_W'(2 * c + 1);

    // set has priority only in name; one write per cycle means never both
    always_ff @(posedge clk) begin
      if (rst) en_q[c] <= 1'b0;
      else if (set_hit[WI] && wdata[BI]) en_q[c] <= 1'b1;
      else if (clr_hit[WI] && wdata[BI]) en_q[c] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        evt_q[c]  <= '1;
        task_q[c] <= '1;
      end else begin
        if (wr_en && addr == AE) evt_q[c]  <= wdata[IDX_W-1:0];
        if (wr_en && addr == AT) task_q[c] <= wdata[IDX_W-1:0];
      end
    end
  end

  always_comb begin
    rd_d = '0;
    if (addr == A_CTRL) rd_d[0] = run_q;
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr == A_STAT + ADDR_W'(c / 32)) rd_d[c % 32] = en_q[c];
      if (addr == A_CFG + ADDR_W'(2 * c))     rd_d[IDX_W-1:0] = evt_q[c];
      if (addr == A_CFG + ADDR_W'(2 * c + 1)) rd_d[IDX_W-1:0] = task_q[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_d;
  end

  assign run     = run_q;
  assign ch_en   = en_q;
  assign ch_evt  = evt_q;
  assign ch_task = task_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (en_q == '0 && !run_q));

  // R2
  set_bits_chk: assert property (@(posedge clk) disable iff (rst)
    set_hit[0] |=> ((en_q[W0-1:0] & $past(wdata[W0-1:0])) == $past(wdata[W0-1:0])));

  // R3
  clr_bits_chk: assert property (@(posedge clk) disable iff (rst)
    clr_hit[0] |=> ((en_q[W0-1:0] & $past(wdata[W0-1:0])) == '0));
endmodule

// File: rtl/evtask_chan.sv
module evtask_chan #(
  parameter int NUM_EVT  = 32,
  parameter int NUM_TASK = 32,
  parameter int IDX_W    = 6
) (
  input  logic                en,
  input  logic [IDX_W-1:0]    evt_idx,
  input  logic [IDX_W-1:0]    task_idx,
  input  logic [NUM_EVT-1:0]  evt_vec,
  output logic [NUM_TASK-1:0] hit
);
  localparam int EVW = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  logic evt_seen;

  // an event index past the last event line never matches
  always_comb begin
    evt_seen = 1'b0;
    if (int'(evt_idx) < NUM_EVT) evt_seen = evt_vec[evt_idx[EVW-1:0]];
  end

  // one-hot task decode; an index at or above NUM_TASK equals no t
  for (genvar t = 0; t < NUM_TASK; t++) begin : g_task
    assign hit[t] = en && evt_seen && (task_idx == IDX_W'(t));
  end
endmodule

// File: rtl/evtask_merge.sv
module evtask_merge #(
  parameter int NUM_CH   = 50,
  parameter int NUM_TASK = 32
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             run,
  input  logic [NUM_CH-1:0][NUM_TASK-1:0]  hits,
  output logic [NUM_TASK-1:0]              task_q
);
  logic [NUM_TASK-1:0] any_hit;

  always_comb begin
    any_hit = '0;
    for (int c = 0; c < NUM_CH; c++) any_hit = any_hit | hits[c];
  end

  always_ff @(posedge clk) begin
    if (rst || !run) task_q <= '0;
    else             task_q <= any_hit;
  end
endmodule

// File: rtl/evtask_matrix.sv
module evtask_matrix
  import evtask_pkg::*;
#(
  parameter int NUM_CH   = 50,
  parameter int NUM_EVT  = 32,
  parameter int NUM_TASK = 32,
  parameter int IDX_W    = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_wr,
  input  logic [7:0]          cfg_addr,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  input  logic [NUM_EVT-1:0]  evt_in,
  output logic [NUM_TASK-1:0] task_out
);
  logic                            run;
  logic [NUM_CH-1:0]               ch_en;
  logic [NUM_CH-1:0][IDX_W-1:0]    ch_evt;
  logic [NUM_CH-1:0][IDX_W-1:0]    ch_task;
  logic [NUM_CH-1:0][NUM_TASK-1:0] hits;

  evtask_regs #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .run(run), .ch_en(ch_en), .ch_evt(ch_evt), .ch_task(ch_task)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    evtask_chan #(.NUM_EVT(NUM_EVT), .NUM_TASK(NUM_TASK), .IDX_W(IDX_W)) u_chan (
      .en(ch_en[c]), .evt_idx(ch_evt[c]), .task_idx(ch_task[c]),
      .evt_vec(evt_in), .hit(hits[c])
    );
  end

  evtask_merge #(.NUM_CH(NUM_CH), .NUM_TASK(NUM_TASK)) u_merge (
    .clk(clk), .rst(rst), .run(run), .hits(hits), .task_q(task_out)
  );

  // R5
  run_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (task_out == '0));

  // R6
  task_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (|task_out) |-> $past(run && (|evt_in)));
endmodule

// File: tb/sim_evtask_matrix.sv
module sim_evtask_matrix;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [31:0] evt_in = '0;
  logic [31:0] task_out;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  evtask_matrix u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .evt_in(evt_in), .task_out(task_out)
  );

  // {event mask, expected task vector}; fixed routing set up beforehand
  localparam logic [63:0] VEC [9] = '{
    {32'h0000_0008, 32'h0000_0220},
    {32'h0000_0080, 32'h0000_0020},
    {32'h0000_0088, 32'h0000_0220},
    {32'h0000_0400, 32'h8000_0000},
    {32'h8000_0000, 32'h0000_0001},
    {32'h0000_1000, 32'h0000_0000},
    {32'h0000_8000, 32'h0000_0000},
    {32'hFFFF_FFFF, 32'h8000_0221},
    {32'h0000_0000, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic pulse(input logic [31:0] m, output logic [31:0] got);
    @(negedge clk);
    evt_in = m;
    @(negedge clk);
    evt_in = '0;
    got = task_out;
  endtask

  task automatic route(input int ch, input int ev, input int tk);
    wr(8'(8'h40 + 2 * ch), 32'(ev));
    wr(8'(8'h41 + 2 * ch), 32'(tk));
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 task_out", task_out, 32'h0);
    rd(8'h04, v); chk("R1 status0", v, 32'h0);
    rd(8'h05, v); chk("R1 status1", v, 32'h0);
    rd(8'h00, v); chk("R1 run", v, 32'h0);
    rd(8'h40, v); chk("R1 ch0 event index", v, 32'h3F);

    route(0, 3, 5);
    route(1, 3, 9);
    route(2, 7, 5);
    route(33, 10, 31);
    route(49, 31, 0);
    route(40, 40, 2);
    route(41, 12, 45);
    route(20, 15, 20);
    wr(8'h08, 32'h0000_0007);
    wr(8'h09, 32'h0002_0302);

    // R4 readback
    rd(8'h04, v); chk("R4 status0", v, 32'h7);
    rd(8'h05, v); chk("R4 status1", v, 32'h0002_0302);
    rd(8'h83, v); chk("R4 ch33 task index", v, 32'd31);

    // R5 run bit clear
    pulse(32'h0000_0008, v); chk("R5 run off", v, 32'h0);

    wr(8'h00, 32'h1);
    rd(8'h00, v); chk("R4 run readback", v, 32'h1);

    // R6 R7 R8 R9 R11 table
    for (int i = 0; i < 9; i++) begin
      pulse(VEC[i][63:32], v);
      chk($sformatf("R6 R7 R8 R9 R11 vec %0d", i), v, VEC[i][31:0]);
    end

    // R6 one-cycle pulse
    pulse(32'h0000_0008, v); chk("R6 pulse", v, 32'h220);
    @(negedge clk); chk("R6 pulse ends", task_out, 32'h0);

    // R10 reconfigure ch0 while enabled, event on the very next cycle
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 8'h40; cfg_wdata = 32'd4;
    @(negedge clk);
    cfg_wr = 1'b0; evt_in = 32'h0000_0010;
    @(negedge clk);
    evt_in = '0;
    chk("R10 new event index", task_out, 32'h20);
    pulse(32'h0000_0008, v); chk("R10 old event index", v, 32'h200);

    // R3 clear ch1, others kept
    wr(8'h0C, 32'h0000_0002);
    rd(8'h04, v); chk("R3 status0", v, 32'h5);
    pulse(32'h0000_0008, v); chk("R3 R7 cleared channel", v, 32'h0);

    // R2 set word1 all ones, unused bits read 0
    wr(8'h09, 32'hFFFF_FFFF);
    rd(8'h05, v); chk("R2 status1", v, 32'h0003_FFFF);
    rd(8'h04, v); chk("R2 status0 kept", v, 32'h5);

    // R5 run cleared again
    wr(8'h00, 32'h0);
    pulse(32'h0000_0010, v); chk("R5 run cleared", v, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule